// File: doc/BRIEF.md
# Byte-Accessed Sixteen-Bit Timer with Coherent Readback

This block is a 16-bit up-counter that an 8-bit processor bus reaches one byte at a time. While it runs, the count climbs by one every clock. When the count equals a programmable 16-bit reload value, the next clock sets it back to 0x0001 and inverts a timer output pin. Software sets the reload value through two byte registers. One control bit starts and stops the count.

A 16-bit count cannot be read in one access on an 8-bit bus. To keep the two halves consistent, a read of the count high byte while the timer runs also copies the live low byte into a holding latch. A later read of the low byte then returns that copy, so both halves come from the same clock. When the timer is stopped, the low byte is read from the counter directly. Writes have no staging. A byte written to either count register goes into the live counter at the next clock edge, and counting continues from the value that results.

Top module: `bytetimer`

## Requirements
- R1: After reset the count is 0x0000, the holding latch is 0x00, the timer output is 0, the timer is stopped (control bit 0 reads 0) and the reload value reads 0xFFFF.
- R2: The bus registers sit at these addresses: 0 = count high byte, 1 = count low byte, 2 = reload high byte, 3 = reload low byte, 4 = control (bit 0 = run). Reads are combinational. Reads of addresses 5 to 7 return 0x00.
- R3: While running, the count rises by exactly one per clock. While stopped, it holds its value unless it is written.
- R4: While running, if the count equals the reload value, the next clock sets the count to 0x0001.
- R5: A read of the count high byte returns the live high byte. If the timer is running during that read, the same clock edge copies the live low byte into the holding latch.
- R6: While running, a read of the count low byte returns the holding latch, not the live low byte.
- R7: While stopped, a read of the count low byte returns the live low byte. A high-byte read while stopped leaves the holding latch unchanged.
- R8: A bus write to the count high or low byte replaces that byte of the counter at the next clock edge. The other byte takes the value it would have had without the write, and counting goes on from the combined value.
- R9: If a count byte write and a reload fall on the same clock, the written byte takes the bus data and the other byte takes its reloaded value.
- R10: Writes to addresses 2 and 3 set the matching byte of the reload value. A write to address 4 sets the run bit from data bit 0.
- R11: The timer output inverts on every clock at which a reload happens and at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe; takes effect at the clock edge |
| bus_rd | input | 1 | Read strobe; a high-byte read captures the low byte at the clock edge |
| bus_rdata | output | 8 | Combinational read data |
| tmr_out | output | 1 | Timer output; inverts on each reload |

## Verification
Two pairs of actions can fall in the same clock. A byte write to the counter can land on the edge where the count wraps. A high-byte capture can land on the edge where the run bit changes. The bench steers the count onto the reload value while stopped, starts the timer, and then writes one count byte in exactly the wrap cycle. It judges the result by stopping the timer and reading both bytes live. It then checks that the unwritten byte holds 0x00 or 0x01 from the reload and that the output has inverted. Random traffic with short reload values makes these collisions happen often, and every read is compared with a bench-side model built from the requirements.

// File: rtl/bytetimer_pkg.sv
package bytetimer_pkg;
  localparam int BUS_W  = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CNT_HI = 3'd0,
    ADR_CNT_LO = 3'd1,
    ADR_RLD_HI = 3'd2,
    ADR_RLD_LO = 3'd3,
    ADR_CTRL   = 3'd4
  } reg_addr_e;

  // Strobes decoded from one bus access
  typedef struct packed {
    logic wr_cnt_hi;
    logic wr_cnt_lo;
    logic wr_rld_hi;
    logic wr_rld_lo;
    logic wr_ctrl;
    logic rd_cnt_hi;
  } bus_dec_t;
endpackage

// File: rtl/bytetimer_rst_sync.sv
module bytetimer_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/bytetimer_regs.sv
module bytetimer_regs
  import bytetimer_pkg::*;
#(
  parameter int BW = BUS_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  bus_dec_t        dec,
  input  logic [BW-1:0]   wdata,
  output logic [2*BW-1:0] reload,
  output logic            run
);
  localparam int CW = 2 * BW;

  logic [CW-1:0] rld_q, rld_d;
  logic          run_q, run_d;
  logic          rld_ce;

  always_comb begin
    rld_d  = rld_q;
    rld_ce = dec.wr_rld_hi | dec.wr_rld_lo;
    if (dec.wr_rld_hi) rld_d[CW-1:BW] = wdata;
    if (dec.wr_rld_lo) rld_d[BW-1:0]  = wdata;
    run_d = dec.wr_ctrl ? wdata[0] : run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_q <= '1;
      run_q <= 1'b0;
    end else begin
      if (rld_ce)      rld_q <= rld_d;
      if (dec.wr_ctrl) run_q <= run_d;
    end
  end

  assign reload = rld_q;
  assign run    = run_q;

  assert_reload_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dec.wr_rld_lo |=> reload[BW-1:0] == $past(wdata));
  assert_reload_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dec.wr_rld_hi |=> reload[CW-1:BW] == $past(wdata));
  assert_reload_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec.wr_rld_hi || dec.wr_rld_lo) |=> $stable(reload));
endmodule

// File: rtl/bytetimer_core.sv
module bytetimer_core
  import bytetimer_pkg::*;
#(
  parameter int BW = BUS_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [2*BW-1:0] reload,
  input  logic            wr_hi,
  input  logic            wr_lo,
  input  logic [BW-1:0]   wdata,
  output logic [2*BW-1:0] count,
  output logic            tmr_out
);
  localparam int CW = 2 * BW;
  localparam logic [CW-1:0] RESTART = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d, cnt_step;
  logic          out_q, out_d;
  logic          at_reload, cnt_ce;

  always_comb begin
    at_reload = run && (cnt_q == reload);
    cnt_step  = at_reload ? RESTART : cnt_q + RESTART;
    cnt_d     = run ? cnt_step : cnt_q;
    if (wr_hi) cnt_d[CW-1:BW] = wdata;
    if (wr_lo) cnt_d[BW-1:0]  = wdata;
    cnt_ce = run | wr_hi | wr_lo;
    out_d  = out_q ^ at_reload;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      if (cnt_ce)    cnt_q <= cnt_d;
      if (at_reload) out_q <= out_d;
    end
  end

  assign count   = cnt_q;
  assign tmr_out = out_q;

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run && (count != reload) && !wr_hi && !wr_lo |=> count == CW'($past(count) + 1'b1));
  assert_count_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !wr_hi && !wr_lo |=> $stable(count));
  assert_reload_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run && (count == reload) && !wr_hi && !wr_lo |=> count == RESTART);
  assert_collide_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run && (count == reload) && wr_lo && !wr_hi |=> count == {{BW{1'b0}}, $past(wdata)});
  assert_write_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> count[CW-1:BW] == $past(wdata));
  assert_out_toggle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    run && (count == reload) |=> tmr_out != $past(tmr_out));
  assert_out_steady_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && (count == reload)) |=> $stable(tmr_out));
endmodule

// File: rtl/bytetimer_readback.sv
module bytetimer_readback
  import bytetimer_pkg::*;
#(
  parameter int BW = BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  bus_dec_t          dec,
  input  logic              run,
  input  logic [2*BW-1:0]   count,
  input  logic [2*BW-1:0]   reload,
  output logic [BW-1:0]     rdata
);
  localparam int CW = 2 * BW;

  logic [BW-1:0] hold_q;
  logic          capture;

  assign capture = dec.rd_cnt_hi & run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (capture) hold_q <= count[BW-1:0];
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADR_CNT_HI: rdata = count[CW-1:BW];
      ADR_CNT_LO: rdata = run ? hold_q : count[BW-1:0];
      ADR_RLD_HI: rdata = reload[CW-1:BW];
      ADR_RLD_LO: rdata = reload[BW-1:0];
      ADR_CTRL:   rdata = {{(BW-1){1'b0}}, run};
      default:    rdata = '0;
    endcase
  end

  assert_hold_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dec.rd_cnt_hi && run |=> hold_q == $past(count[BW-1:0]));
  assert_hold_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec.rd_cnt_hi && run) |=> $stable(hold_q));
endmodule

// File: rtl/bytetimer.sv
module bytetimer
  import bytetimer_pkg::*;
#(
  parameter int BW = BUS_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [BW-1:0] bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [BW-1:0] bus_rdata,
  output logic          tmr_out
);
  localparam int CW = 2 * BW;

  logic          rst_n_s;
  bus_dec_t      dec;
  logic [CW-1:0] reload, count;
  logic          run;

  bytetimer_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  always_comb begin
    dec.wr_cnt_hi = bus_wr && (bus_addr == ADR_CNT_HI);
    dec.wr_cnt_lo = bus_wr && (bus_addr == ADR_CNT_LO);
    dec.wr_rld_hi = bus_wr && (bus_addr == ADR_RLD_HI);
    dec.wr_rld_lo = bus_wr && (bus_addr == ADR_RLD_LO);
    dec.wr_ctrl   = bus_wr && (bus_addr == ADR_CTRL);
    dec.rd_cnt_hi = bus_rd && (bus_addr == ADR_CNT_HI);
  end

  bytetimer_regs #(.BW(BW)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .dec(dec), .wdata(bus_wdata),
    .reload(reload), .run(run));

  bytetimer_core #(.BW(BW)) u_core (
    .clk(clk), .rst_n(rst_n_s), .run(run), .reload(reload),
    .wr_hi(dec.wr_cnt_hi), .wr_lo(dec.wr_cnt_lo), .wdata(bus_wdata),
    .count(count), .tmr_out(tmr_out));

  bytetimer_readback #(.BW(BW)) u_rb (
    .clk(clk), .rst_n(rst_n_s), .addr(bus_addr), .dec(dec), .run(run),
    .count(count), .reload(reload), .rdata(bus_rdata));
endmodule

// File: tb/bytetimer_bench.sv
`timescale 1ns/1ps
module bytetimer_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_rdata;
  logic       tmr_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench-side model of the requirements
  logic [15:0] m_cnt, m_rld;
  logic [7:0]  m_hold;
  logic        m_run, m_out;

  always #4 clk = ~clk;

  bytetimer u_bytetimer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .tmr_out(tmr_out));

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return m_cnt[15:8];
      3'd1: return m_run ? m_hold : m_cnt[7:0];
      3'd2: return m_rld[15:8];
      3'd3: return m_rld[7:0];
      3'd4: return {7'd0, m_run};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string read_tag(input logic [2:0] a);
    case (a)
      3'd0: return "R5";
      3'd1: return m_run ? "R6" : "R7";
      3'd2, 3'd3, 3'd4: return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one bus cycle; called at a falling edge, returns at the next falling edge
  task automatic step(input logic [2:0] a, input logic [7:0] d, input logic w,
                      input logic r, input string tag);
    logic [15:0] n;
    logic        wrap;
    bus_addr = a; bus_wdata = d; bus_wr = w; bus_rd = r;
    #1;
    if (r) check({8'd0, bus_rdata}, {8'd0, exp_read(a)}, tag);
    @(posedge clk);
    wrap = m_run && (m_cnt == m_rld);
    n = m_cnt;
    if (m_run) n = wrap ? 16'h0001 : m_cnt + 16'd1;
    if (w && a == 3'd0) n[15:8] = d;
    if (w && a == 3'd1) n[7:0]  = d;
    if (r && a == 3'd0 && m_run) m_hold = m_cnt[7:0];
    if (w && a == 3'd2) m_rld[15:8] = d;
    if (w && a == 3'd3) m_rld[7:0]  = d;
    if (w && a == 3'd4) m_run = d[0];
    m_cnt = n;
    if (wrap) m_out = ~m_out;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check({15'd0, tmr_out}, {15'd0, m_out}, "R11");
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    step(a, 8'h00, 1'b0, 1'b1, tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    step(a, d, 1'b1, 1'b0, "R8");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 0; bus_rd = 0;
    m_cnt = 16'h0000; m_rld = 16'hFFFF; m_hold = 8'h00; m_run = 0; m_out = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    rd(3'd0, "R1"); rd(3'd1, "R1"); rd(3'd2, "R1"); rd(3'd3, "R1"); rd(3'd4, "R1");
    check({15'd0, tmr_out}, 16'd0, "R1");
    rd(3'd6, "R2");

    // R10: reload of 0x0005, then run and watch the wrap (R3, R4, R11)
    wr(3'd2, 8'h00); wr(3'd3, 8'h05);
    rd(3'd2, "R10"); rd(3'd3, "R10");
    wr(3'd4, 8'h01);
    for (int i = 0; i < 12; i++) rd(3'd0, "R4");
    rd(3'd1, "R6");

    // R3: stopped counter holds; R7 live low read
    wr(3'd4, 8'h00);
    rd(3'd1, "R7"); rd(3'd1, "R3");

    // R5/R6: coherent read while running
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    wr(3'd0, 8'h12); wr(3'd1, 8'hF0);
    wr(3'd4, 8'h01);
    step(3'd7, 8'h00, 1'b0, 1'b0, "R3");
    rd(3'd0, "R5");
    repeat (5) step(3'd7, 8'h00, 1'b0, 1'b0, "R3");
    rd(3'd1, "R6");

    // R8: byte write while running, counting continues
    wr(3'd0, 8'h40);
    rd(3'd0, "R8"); rd(3'd1, "R8");
    wr(3'd4, 8'h00);
    rd(3'd0, "R8"); rd(3'd1, "R8");

    // R7: high read while stopped leaves the latch
    wr(3'd1, 8'hA5);
    rd(3'd0, "R7");
    wr(3'd4, 8'h01);
    rd(3'd1, "R7");

    // R9: low-byte write in the wrap cycle
    wr(3'd4, 8'h00);
    wr(3'd2, 8'h00); wr(3'd3, 8'h10);
    wr(3'd0, 8'h00); wr(3'd1, 8'h10);
    wr(3'd4, 8'h01);
    step(3'd1, 8'h55, 1'b1, 1'b0, "R9");
    wr(3'd4, 8'h00);
    rd(3'd0, "R9"); rd(3'd1, "R9");
    // R9: high-byte write in the wrap cycle
    wr(3'd0, 8'h00); wr(3'd1, 8'h10);
    wr(3'd4, 8'h01);
    step(3'd0, 8'h77, 1'b1, 1'b0, "R9");
    wr(3'd4, 8'h00);
    rd(3'd0, "R9"); rd(3'd1, "R9");

    // random traffic with short reload values
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] a;
      logic [7:0] d;
      logic       w, r;
      a = 3'($urandom_range(0, 7));
      d = 8'($urandom);
      w = ($urandom_range(0, 3) == 0);
      r = ($urandom_range(0, 1) == 0);
      if (a == 3'd2) d = ($urandom_range(0, 7) == 0) ? d : 8'h00;
      if (a == 3'd4) d[0] = ($urandom_range(0, 4) != 0);
      if (a == 3'd0 && w) d = ($urandom_range(0, 1) == 0) ? 8'h00 : d;
      step(a, d, w, r, r ? read_tag(a) : "R8");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule